// File: doc/BRIEF.md
# Mailbox Packet Channel Handshake Controller

This block is the controller-side state machine of a packet channel that a host and a management controller share over a shared memory window and a one-byte mailbox. The mailbox supplies an inbound data byte with a full flag (written by the host), an outbound data byte with a full flag (read by the host), and a status byte that the controller writes. Bit 7 of that status byte means "controller active" and bit 6 means "channel linked". The controller announces itself as active once its control fields are valid. When the host sends an Initialise command, it negotiates a protocol version and checks the buffer layout. The host is then told of every change of status through a status write, followed by a filler byte in the outbound data register.

Once linked, each direction's packet area is tracked as an ownership token that moves only on explicit commands. When the host sends Tx Begin, the inbound area passes to the local side, which raises a packet event. The local side hands the area back through a release input, and the controller sends Rx Complete. For the outbound area, the local side asks for a transfer with a request/grant handshake. The controller then sends Tx Begin and waits for the host's Rx Complete before it marks the area as free again. Moving the buffer data and computing checksums are handled elsewhere.

Top module: `mbx_link_ctrl`

## Requirements
- R1: After reset, the status stays 0x00 and nothing is written until `cfg_ready` is high. The controller then writes status 0x80 (bit 7 active), followed by the filler code 0xFF to the outbound data register.
- R2: A status write always comes before its filler write. No outbound data write is issued while `mbx_obf` is set. A queued write is held until the host has read the register, and two outbound writes never fall in adjacent cycles.
- R3: On Initialise (code 0x00), the negotiated version is the smaller of the two current versions. It is accepted only if it is nonzero and at least the larger of the two minimum versions. Otherwise negotiation fails and `neg_ver` reads 0.
- R4: The layout is rejected in four cases: either area starts inside the control region [0, CTRL_BYTES); either area ends past `win_size`; the two areas overlap; or either area is smaller than BTU+4 bytes (BTU+8 bytes when the version is 3 or higher).
- R5: A successful Initialise pulses `neg_valid` with `neg_ok`=1. From version 2 onward, both area sizes become `host_req_size`; for version 1 they stay as configured. Success resets both ownership tokens, writes status 0xC0 and queues the filler.
- R6: A failed Initialise leaves the channel unlinked. If the channel was linked, status 0x80 is written with a filler. If it was not linked, no status or filler write is made.
- R7: While linked, host Tx Begin (0x01) hands the inbound area to the local side with one `rx_pkt` pulse. A further Tx Begin while the area is still held is ignored.
- R8: A `rx_release` pulse while the inbound area is held sends Rx Complete (0x02). `ib_held` falls only after that command has been written.
- R9: While linked and the outbound area is free, `tx_req` gets a single `tx_gnt` pulse and queues Tx Begin (0x01). `ob_free` stays low until the host's Rx Complete (0x02) arrives after that Tx Begin has been sent.
- R10: While not linked, Tx Begin and Rx Complete from the host have no effect, and `tx_req` is not granted.
- R11: Command codes other than 0x00, 0x01 and 0x02 are read (to acknowledge them) and otherwise ignored.
- R12: When several outbound writes are pending, they go out in priority order: filler 0xFF first, then Rx Complete 0x02, then Tx Begin 0x01.
- R13: Each host command is read exactly once, with a one-cycle `mbx_idr_rd` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ready | input | 1 | Control fields are valid |
| loc_ver_min | input | 16 | Lowest version the controller supports |
| loc_ver_cur | input | 16 | Highest version the controller supports |
| host_ver_min | input | 16 | Lowest version the host supports |
| host_ver_cur | input | 16 | Highest version the host supports |
| host_req_size | input | 32 | Area size proposed by the host |
| ib_off | input | 32 | Start offset of the inbound area (host to controller) |
| ib_size | input | 32 | Configured size of the inbound area |
| ob_off | input | 32 | Start offset of the outbound area (controller to host) |
| ob_size | input | 32 | Configured size of the outbound area |
| win_size | input | 32 | Size of the shared window in bytes |
| mbx_ibf | input | 1 | Inbound data register full |
| mbx_idr_data | input | 8 | Inbound data byte |
| mbx_idr_rd | output | 1 | Read strobe for the inbound data register |
| mbx_obf | input | 1 | Outbound data register full |
| mbx_odr_wr | output | 1 | Write strobe for the outbound data register |
| mbx_odr_data | output | 8 | Outbound data byte |
| mbx_str_wr | output | 1 | Status register write strobe |
| mbx_str_data | output | 8 | Status byte (held between writes) |
| neg_valid | output | 1 | One-cycle pulse with the negotiation result |
| neg_ok | output | 1 | Negotiation succeeded |
| neg_ver | output | 16 | Negotiated version (0 on failure) |
| neg_ib_size | output | 32 | Negotiated inbound area size |
| neg_ob_size | output | 32 | Negotiated outbound area size |
| tx_req | input | 1 | Local request to send the outbound packet |
| tx_gnt | output | 1 | Request accepted, Tx Begin queued |
| ob_free | output | 1 | Outbound area owned locally |
| rx_pkt | output | 1 | Inbound packet handed to the local side |
| ib_held | output | 1 | Inbound area owned locally |
| rx_release | input | 1 | Local side has finished with the inbound area |

## Verification
The bench goes after version windows that do not overlap and the version 3 trailer that raises the minimum area size. A design that took the larger version, or that ignored the trailer, would report a link the host cannot use. The bench also tests overlapping areas, areas that reach into the control region and areas that run past the window, each of which must fail. It holds the outbound full flag while a filler, an Rx Complete and a Tx Begin all wait. A design that wrote over an unread byte, or that sent them in the wrong order, would lose a status announcement or hand over a buffer early. It repeats Tx Begin commands, sends Rx Complete when the area is already free, and sends unknown codes and commands before the link is up. A design whose tokens were not strict would raise duplicate packet events or grant the outbound area twice.

// File: rtl/mlc_pkg.sv
package mlc_pkg;

    localparam int VER_W  = 16;
    localparam int ADDR_W = 32;

    localparam logic [7:0] CMD_INIT   = 8'h00;
    localparam logic [7:0] CMD_TXBEG  = 8'h01;
    localparam logic [7:0] CMD_RXDONE = 8'h02;
    localparam logic [7:0] CMD_FILLER = 8'hFF;

    localparam int STAT_ACTIVE_BIT = 7;
    localparam int STAT_LINK_BIT   = 6;

    typedef enum logic [1:0] {
        LS_DOWN,
        LS_UP,
        LS_LINKED
    } link_state_e;

    typedef enum logic [1:0] {
        OD_NONE,
        OD_FILLER,
        OD_RXDONE,
        OD_TXBEG
    } odr_item_e;

    typedef struct packed {
        logic              ok;
        logic [VER_W-1:0]  ver;
        logic [ADDR_W-1:0] ib_size;
        logic [ADDR_W-1:0] ob_size;
    } neg_res_t;

    function automatic logic [7:0] item_code(odr_item_e it);
        case (it)
            OD_FILLER: return CMD_FILLER;
            OD_RXDONE: return CMD_RXDONE;
            OD_TXBEG:  return CMD_TXBEG;
            default:   return CMD_FILLER;
        endcase
    endfunction

    function automatic logic spans_meet(logic [ADDR_W:0] a_lo, logic [ADDR_W:0] a_hi,
                                        logic [ADDR_W:0] b_lo, logic [ADDR_W:0] b_hi);
        return (a_lo < b_hi) && (b_lo < a_hi);
    endfunction

endpackage

// File: rtl/mlc_negotiate.sv
module mlc_negotiate
    import mlc_pkg::*;
#(
    parameter int BTU        = 64,
    parameter int CTRL_BYTES = 28,
    parameter int LEN_BYTES  = 4,
    parameter int CRC_BYTES  = 4,
    parameter int MTU_VER    = 2,
    parameter int TRL_VER    = 3
) (
    input  logic [VER_W-1:0]  loc_ver_min,
    input  logic [VER_W-1:0]  loc_ver_cur,
    input  logic [VER_W-1:0]  host_ver_min,
    input  logic [VER_W-1:0]  host_ver_cur,
    input  logic [ADDR_W-1:0] host_req_size,
    input  logic [ADDR_W-1:0] ib_off,
    input  logic [ADDR_W-1:0] ib_size,
    input  logic [ADDR_W-1:0] ob_off,
    input  logic [ADDR_W-1:0] ob_size,
    input  logic [ADDR_W-1:0] win_size,
    output neg_res_t          res
);

    localparam logic [ADDR_W-1:0] BASE_NEED = ADDR_W'(BTU + LEN_BYTES);
    localparam logic [ADDR_W-1:0] TRL_NEED  = ADDR_W'(CRC_BYTES);
    localparam logic [ADDR_W:0]   CTRL_END  = (ADDR_W+1)'(CTRL_BYTES);

    logic [VER_W-1:0]  ver_hi, ver_lo;
    logic              ver_ok, sizes_ok, fit_ok, apart_ok;
    logic [ADDR_W-1:0] use_ib, use_ob, need;
    logic [ADDR_W:0]   ib_lo, ib_hi, ob_lo, ob_hi, win_end;

    always_comb begin
        ver_hi = (loc_ver_cur < host_ver_cur) ? loc_ver_cur : host_ver_cur;
        ver_lo = (loc_ver_min > host_ver_min) ? loc_ver_min : host_ver_min;
        ver_ok = (ver_hi != '0) && (ver_hi >= ver_lo);

        if (ver_hi >= VER_W'(MTU_VER)) begin
            use_ib = host_req_size;
            use_ob = host_req_size;
        end else begin
            use_ib = ib_size;
            use_ob = ob_size;
        end

        need = BASE_NEED + ((ver_hi >= VER_W'(TRL_VER)) ? TRL_NEED : '0);

        ib_lo   = {1'b0, ib_off};
        ib_hi   = ib_lo + {1'b0, use_ib};
        ob_lo   = {1'b0, ob_off};
        ob_hi   = ob_lo + {1'b0, use_ob};
        win_end = {1'b0, win_size};

        sizes_ok = (use_ib >= need) && (use_ob >= need);
        fit_ok   = (ib_hi <= win_end) && (ob_hi <= win_end);
        apart_ok = !spans_meet(ib_lo, ib_hi, ob_lo, ob_hi)
                   && (ib_lo >= CTRL_END) && (ob_lo >= CTRL_END);

        res.ok      = ver_ok && sizes_ok && fit_ok && apart_ok;
        res.ver     = ver_ok ? ver_hi : '0;
        res.ib_size = use_ib;
        res.ob_size = use_ob;
    end

endmodule

// File: rtl/mlc_cmd_rx.sv
module mlc_cmd_rx
    import mlc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ibf,
    input  logic [7:0] idr_data,
    output logic       idr_rd,
    output logic       cmd_valid,
    output logic [7:0] cmd_code
);

    logic rd_hold;

    // rd_hold covers the cycle in which the mailbox clears its full flag
    assign idr_rd = ibf && !rd_hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_hold   <= 1'b0;
            cmd_valid <= 1'b0;
            cmd_code  <= CMD_FILLER;
        end else begin
            rd_hold   <= idr_rd;
            cmd_valid <= idr_rd;
            if (idr_rd) begin
                cmd_code <= idr_data;
            end
        end
    end

endmodule

// File: rtl/mlc_odr_sched.sv
module mlc_odr_sched
    import mlc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       obf,
    input  logic       set_filler,
    input  logic       set_rxdone,
    input  logic       set_txbeg,
    input  logic       flush,
    output logic       odr_wr,
    output logic [7:0] odr_data,
    output logic       sent_rxdone,
    output logic       sent_txbeg,
    output logic       pend_rxdone,
    output logic       pend_txbeg
);

    logic      pend_filler;
    odr_item_e pick;
    logic      go;

    always_comb begin
        if (pend_filler)      pick = OD_FILLER;
        else if (pend_rxdone) pick = OD_RXDONE;
        else if (pend_txbeg)  pick = OD_TXBEG;
        else                  pick = OD_NONE;
        go = (pick != OD_NONE) && !obf && !odr_wr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_filler <= 1'b0;
            pend_rxdone <= 1'b0;
            pend_txbeg  <= 1'b0;
            odr_wr      <= 1'b0;
            odr_data    <= CMD_FILLER;
            sent_rxdone <= 1'b0;
            sent_txbeg  <= 1'b0;
        end else begin
            odr_wr      <= go;
            sent_rxdone <= go && (pick == OD_RXDONE);
            sent_txbeg  <= go && (pick == OD_TXBEG);
            if (go) begin
                odr_data <= item_code(pick);
            end
            pend_filler <= set_filler || (pend_filler && !(go && pick == OD_FILLER));
            pend_rxdone <= !flush && (set_rxdone || (pend_rxdone && !(go && pick == OD_RXDONE)));
            pend_txbeg  <= !flush && (set_txbeg  || (pend_txbeg  && !(go && pick == OD_TXBEG)));
        end
    end

endmodule

// File: rtl/mbx_link_ctrl.sv
module mbx_link_ctrl
    import mlc_pkg::*;
#(
    parameter int BTU        = 64,
    parameter int CTRL_BYTES = 28,
    parameter int LEN_BYTES  = 4,
    parameter int CRC_BYTES  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_ready,
    input  logic [15:0]       loc_ver_min,
    input  logic [15:0]       loc_ver_cur,
    input  logic [15:0]       host_ver_min,
    input  logic [15:0]       host_ver_cur,
    input  logic [31:0]       host_req_size,
    input  logic [31:0]       ib_off,
    input  logic [31:0]       ib_size,
    input  logic [31:0]       ob_off,
    input  logic [31:0]       ob_size,
    input  logic [31:0]       win_size,
    input  logic              mbx_ibf,
    input  logic [7:0]        mbx_idr_data,
    output logic              mbx_idr_rd,
    input  logic              mbx_obf,
    output logic              mbx_odr_wr,
    output logic [7:0]        mbx_odr_data,
    output logic              mbx_str_wr,
    output logic [7:0]        mbx_str_data,
    output logic              neg_valid,
    output logic              neg_ok,
    output logic [15:0]       neg_ver,
    output logic [31:0]       neg_ib_size,
    output logic [31:0]       neg_ob_size,
    input  logic              tx_req,
    output logic              tx_gnt,
    output logic              ob_free,
    output logic              rx_pkt,
    output logic              ib_held,
    input  logic              rx_release
);

    localparam logic [7:0] STAT_UP     = 8'(1 << STAT_ACTIVE_BIT);
    localparam logic [7:0] STAT_LINKED = STAT_UP | 8'(1 << STAT_LINK_BIT);

    link_state_e state, nxt_state;
    logic [7:0]  nxt_str;
    logic        str_we;
    logic        cmd_valid;
    logic [7:0]  cmd_code;
    neg_res_t    neg;
    logic        set_filler, set_rxdone, set_txbeg, flush;
    logic        sent_rxdone, sent_txbeg, pend_rxdone, pend_txbeg;
    logic        do_neg, take_in, accept_tx, rearm;
    logic        txbeg_out;

    mlc_cmd_rx u_cmd (
        .clk       (clk),
        .rst       (rst),
        .ibf       (mbx_ibf),
        .idr_data  (mbx_idr_data),
        .idr_rd    (mbx_idr_rd),
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code)
    );

    mlc_negotiate #(
        .BTU        (BTU),
        .CTRL_BYTES (CTRL_BYTES),
        .LEN_BYTES  (LEN_BYTES),
        .CRC_BYTES  (CRC_BYTES)
    ) u_neg (
        .loc_ver_min   (loc_ver_min),
        .loc_ver_cur   (loc_ver_cur),
        .host_ver_min  (host_ver_min),
        .host_ver_cur  (host_ver_cur),
        .host_req_size (host_req_size),
        .ib_off        (ib_off),
        .ib_size       (ib_size),
        .ob_off        (ob_off),
        .ob_size       (ob_size),
        .win_size      (win_size),
        .res           (neg)
    );

    mlc_odr_sched u_sched (
        .clk         (clk),
        .rst         (rst),
        .obf         (mbx_obf),
        .set_filler  (set_filler),
        .set_rxdone  (set_rxdone),
        .set_txbeg   (set_txbeg),
        .flush       (flush),
        .odr_wr      (mbx_odr_wr),
        .odr_data    (mbx_odr_data),
        .sent_rxdone (sent_rxdone),
        .sent_txbeg  (sent_txbeg),
        .pend_rxdone (pend_rxdone),
        .pend_txbeg  (pend_txbeg)
    );

    always_comb begin
        nxt_state  = state;
        nxt_str    = mbx_str_data;
        str_we     = 1'b0;
        set_filler = 1'b0;
        set_rxdone = 1'b0;
        set_txbeg  = 1'b0;
        flush      = 1'b0;
        do_neg     = 1'b0;
        take_in    = 1'b0;
        accept_tx  = 1'b0;
        rearm      = 1'b0;
        case (state)
            LS_DOWN: begin
                if (cfg_ready) begin
                    nxt_state  = LS_UP;
                    nxt_str    = STAT_UP;
                    str_we     = 1'b1;
                    set_filler = 1'b1;
                end
            end
            default: begin
                if (cmd_valid && cmd_code == CMD_INIT) begin
                    do_neg = 1'b1;
                    flush  = 1'b1;
                    if (neg.ok) begin
                        nxt_state  = LS_LINKED;
                        nxt_str    = STAT_LINKED;
                        str_we     = 1'b1;
                        set_filler = 1'b1;
                    end else begin
                        nxt_state = LS_UP;
                        if (state == LS_LINKED) begin
                            nxt_str    = STAT_UP;
                            str_we     = 1'b1;
                            set_filler = 1'b1;
                        end
                    end
                end else if (state == LS_LINKED) begin
                    take_in = cmd_valid && (cmd_code == CMD_TXBEG) && !ib_held;
                    rearm   = cmd_valid && (cmd_code == CMD_RXDONE) && txbeg_out;
                    set_rxdone = rx_release && ib_held && !pend_rxdone;
                    accept_tx  = tx_req && ob_free;
                    set_txbeg  = accept_tx;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= LS_DOWN;
            mbx_str_data <= '0;
            mbx_str_wr   <= 1'b0;
            neg_valid    <= 1'b0;
            neg_ok       <= 1'b0;
            neg_ver      <= '0;
            neg_ib_size  <= '0;
            neg_ob_size  <= '0;
            tx_gnt       <= 1'b0;
            rx_pkt       <= 1'b0;
            ib_held      <= 1'b0;
            ob_free      <= 1'b1;
            txbeg_out    <= 1'b0;
        end else begin
            state      <= nxt_state;
            mbx_str_wr <= str_we;
            if (str_we) begin
                mbx_str_data <= nxt_str;
            end
            neg_valid <= do_neg;
            if (do_neg) begin
                neg_ok      <= neg.ok;
                neg_ver     <= neg.ver;
                neg_ib_size <= neg.ib_size;
                neg_ob_size <= neg.ob_size;
            end
            tx_gnt <= accept_tx;
            rx_pkt <= take_in;
            if (flush) begin
                ib_held   <= 1'b0;
                ob_free   <= 1'b1;
                txbeg_out <= 1'b0;
            end else begin
                if (take_in) begin
                    ib_held <= 1'b1;
                end else if (sent_rxdone) begin
                    ib_held <= 1'b0;
                end
                if (accept_tx) begin
                    ob_free <= 1'b0;
                end else if (rearm) begin
                    ob_free <= 1'b1;
                end
                if (sent_txbeg) begin
                    txbeg_out <= 1'b1;
                end else if (rearm) begin
                    txbeg_out <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/mlc_checker.sv
module mlc_checker (
    input logic       clk,
    input logic       rst,
    input logic       mbx_obf,
    input logic       mbx_odr_wr,
    input logic       mbx_idr_rd,
    input logic       mbx_str_wr,
    input logic [7:0] mbx_str_data,
    input logic       tx_req,
    input logic       tx_gnt,
    input logic       ob_free,
    input logic       rx_pkt,
    input logic       ib_held
);

    // R2: outbound byte written only if the host had emptied the register
    a_r2_odr_waits_obf: assert property (@(posedge clk) disable iff (rst)
        mbx_odr_wr |-> !$past(mbx_obf));

    // R2: two outbound writes are never back to back
    a_r2_odr_spacing: assert property (@(posedge clk) disable iff (rst)
        mbx_odr_wr |=> !mbx_odr_wr);

    // R13: one read pulse per command
    a_r13_single_read: assert property (@(posedge clk) disable iff (rst)
        mbx_idr_rd |=> !mbx_idr_rd);

    // R7: a packet event only moves a free inbound area into local hands
    a_r7_take_fresh: assert property (@(posedge clk) disable iff (rst)
        rx_pkt |-> (ib_held && !$past(ib_held)));

    // R9: a grant consumes a free outbound area that was requested
    a_r9_grant_token: assert property (@(posedge clk) disable iff (rst)
        tx_gnt |-> (!ob_free && $past(ob_free) && $past(tx_req)));

    // R10: grants only while the status reports a linked channel
    a_r10_grant_linked: assert property (@(posedge clk) disable iff (rst)
        tx_gnt |-> $past(mbx_str_data[6]));

    // R1: every status write carries the active bit
    a_r1_str_active: assert property (@(posedge clk) disable iff (rst)
        mbx_str_wr |-> mbx_str_data[7]);

endmodule

bind mbx_link_ctrl mlc_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .mbx_obf      (mbx_obf),
    .mbx_odr_wr   (mbx_odr_wr),
    .mbx_idr_rd   (mbx_idr_rd),
    .mbx_str_wr   (mbx_str_wr),
    .mbx_str_data (mbx_str_data),
    .tx_req       (tx_req),
    .tx_gnt       (tx_gnt),
    .ob_free      (ob_free),
    .rx_pkt       (rx_pkt),
    .ib_held      (ib_held)
);

// File: tb/sim_mbx_link_ctrl.sv
module sim_mbx_link_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_ready = 1'b0;
    logic [15:0] loc_ver_min = 16'd1, loc_ver_cur = 16'd3;
    logic [15:0] host_ver_min = 16'd1, host_ver_cur = 16'd3;
    logic [31:0] host_req_size = 32'h100;
    logic [31:0] ib_off = 32'h100, ib_size = 32'h100;
    logic [31:0] ob_off = 32'h200, ob_size = 32'h100;
    logic [31:0] win_size = 32'h1000;
    logic        ibf, obf;
    logic [7:0]  idr;
    logic        idr_rd, odr_wr, str_wr;
    logic [7:0]  odr_data, str_data;
    logic        neg_valid, neg_ok;
    logic [15:0] neg_ver;
    logic [31:0] neg_ib_size, neg_ob_size;
    logic        tx_req = 1'b0, tx_gnt, ob_free, rx_pkt, ib_held;
    logic        rx_release = 1'b0;

    always #2 clk = ~clk;

    mbx_link_ctrl u0 (
        .clk(clk), .rst(rst), .cfg_ready(cfg_ready),
        .loc_ver_min(loc_ver_min), .loc_ver_cur(loc_ver_cur),
        .host_ver_min(host_ver_min), .host_ver_cur(host_ver_cur),
        .host_req_size(host_req_size), .ib_off(ib_off), .ib_size(ib_size),
        .ob_off(ob_off), .ob_size(ob_size), .win_size(win_size),
        .mbx_ibf(ibf), .mbx_idr_data(idr), .mbx_idr_rd(idr_rd),
        .mbx_obf(obf), .mbx_odr_wr(odr_wr), .mbx_odr_data(odr_data),
        .mbx_str_wr(str_wr), .mbx_str_data(str_data),
        .neg_valid(neg_valid), .neg_ok(neg_ok), .neg_ver(neg_ver),
        .neg_ib_size(neg_ib_size), .neg_ob_size(neg_ob_size),
        .tx_req(tx_req), .tx_gnt(tx_gnt), .ob_free(ob_free),
        .rx_pkt(rx_pkt), .ib_held(ib_held), .rx_release(rx_release)
    );

    // host-side mailbox model
    int         cmd_seq = 0, cmd_seen = 0, rd_seq = 0, rd_seen = 0;
    logic [7:0] cmd_buf = 8'h00;
    logic       auto_read = 1'b1;

    always @(posedge clk) begin
        if (rst) begin
            ibf <= 1'b0; obf <= 1'b0; idr <= 8'h00;
            cmd_seen <= cmd_seq; rd_seen <= rd_seq;
        end else begin
            if (idr_rd) ibf <= 1'b0;
            else if (!ibf && cmd_seen != cmd_seq) begin
                ibf <= 1'b1; idr <= cmd_buf; cmd_seen <= cmd_seen + 1;
            end
            if (odr_wr) obf <= 1'b1;
            else if (obf && (auto_read || rd_seen != rd_seq)) begin
                obf <= 1'b0; rd_seen <= rd_seq;
            end
        end
    end

    // scoreboard
    typedef struct {
        logic       is_odr;
        logic [7:0] val;
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    int mon_vec = 0, mon_bad = 0, chk_vec = 0, chk_bad = 0;
    int odr_cnt = 0, gnt_cnt = 0, pkt_cnt = 0, rd_cnt = 0;

    task automatic expect_item(input logic is_odr, input logic [7:0] v, input string tag);
        exp_t e;
        e.is_odr = is_odr; e.val = v; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic mon_cmp(input logic is_odr, input logic [7:0] v);
        exp_t e;
        mon_vec++;
        if (exp_q.size() == 0) begin
            mon_bad++;
            $display("FAIL unexpected %s write: actual %02h expected none", is_odr ? "odr" : "status", v);
        end else begin
            e = exp_q.pop_front();
            if (e.is_odr != is_odr || e.val != v) begin
                mon_bad++;
                $display("FAIL %s: actual %s %02h expected %s %02h", e.tag,
                         is_odr ? "odr" : "status", v, e.is_odr ? "odr" : "status", e.val);
            end
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (str_wr) mon_cmp(1'b0, str_data);
            if (odr_wr) begin mon_cmp(1'b1, odr_data); odr_cnt++; end
            if (tx_gnt) gnt_cnt++;
            if (rx_pkt) pkt_cnt++;
            if (idr_rd) rd_cnt++;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        chk_vec++;
        if (act !== exp) begin
            chk_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic host_cmd(input logic [7:0] c);
        @(negedge clk);
        while (cmd_seen != cmd_seq || ibf) @(negedge clk);
        cmd_buf = c;
        cmd_seq++;
        repeat (10) @(negedge clk);
    endtask

    task automatic host_read();
        @(negedge clk);
        rd_seq++;
        repeat (5) @(negedge clk);
    endtask

    task automatic pulse_release();
        @(negedge clk);
        rx_release = 1'b1;
        @(negedge clk);
        rx_release = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic do_grant();
        int g0;
        g0 = gnt_cnt;
        @(negedge clk);
        tx_req = 1'b1;
        while (gnt_cnt == g0) @(negedge clk);
        tx_req = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    logic done = 1'b0;

    initial begin
        int p0, g0, o0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (10) @(negedge clk);
        chk("R1 status before cfg_ready", {24'h0, str_data}, 32'h00);
        chk("R1 no write before cfg_ready", odr_cnt, 0);

        expect_item(1'b0, 8'h80, "R1 active status");
        expect_item(1'b1, 8'hFF, "R1 filler after active");
        cfg_ready = 1'b1;
        repeat (10) @(negedge clk);
        chk("R1 announce drained", exp_q.size(), 0);

        // R11 unknown code, R10 commands/requests while unlinked
        host_cmd(8'h55);
        host_cmd(8'h01);
        host_cmd(8'h02);
        chk("R10 no packet event unlinked", pkt_cnt, 0);
        @(negedge clk); tx_req = 1'b1;
        repeat (12) @(negedge clk); tx_req = 1'b0;
        chk("R10 no grant unlinked", gnt_cnt, 0);
        chk("R11 unknown code no write", exp_q.size(), 0);
        chk("R11 status unchanged", {24'h0, str_data}, 32'h80);

        // R3/R5 version 3 success
        expect_item(1'b0, 8'hC0, "R5 linked status");
        expect_item(1'b1, 8'hFF, "R5 filler");
        host_cmd(8'h00);
        chk("R5 neg ok", neg_ok, 1);
        chk("R3 version 3", neg_ver, 3);
        chk("R5 ob size v3", neg_ob_size, 32'h100);

        // R3 disjoint versions -> R6 unlink with announcement
        host_ver_min = 16'd4; host_ver_cur = 16'd5;
        expect_item(1'b0, 8'h80, "R6 unlink status");
        expect_item(1'b1, 8'hFF, "R6 unlink filler");
        host_cmd(8'h00);
        chk("R3 disjoint fails", neg_ok, 0);
        chk("R3 failed version zero", neg_ver, 0);
        o0 = odr_cnt;
        host_cmd(8'h00);
        chk("R6 failure while unlinked silent", odr_cnt, o0);
        chk("R6 status stays 80", {24'h0, str_data}, 32'h80);

        // R3 picks smaller current version
        host_ver_min = 16'd1; host_ver_cur = 16'd2;
        expect_item(1'b0, 8'hC0, "R5 relink status");
        expect_item(1'b1, 8'hFF, "R5 relink filler");
        host_cmd(8'h00);
        chk("R3 version 2", neg_ver, 2);

        // R4 trailer raises minimum size
        host_req_size = 32'd68; host_ver_cur = 16'd3;
        expect_item(1'b0, 8'h80, "R4 v3 size 68 rejected");
        expect_item(1'b1, 8'hFF, "R4 filler");
        host_cmd(8'h00);
        chk("R4 v3 size 68 fails", neg_ok, 0);
        host_ver_cur = 16'd2;
        expect_item(1'b0, 8'hC0, "R4 v2 size 68 accepted");
        expect_item(1'b1, 8'hFF, "R4 filler");
        host_cmd(8'h00);
        chk("R4 v2 size 68 ok", neg_ok, 1);
        chk("R5 ib size follows request", neg_ib_size, 68);
        host_req_size = 32'd67;
        expect_item(1'b0, 8'h80, "R4 size 67 rejected");
        expect_item(1'b1, 8'hFF, "R4 filler");
        host_cmd(8'h00);
        chk("R4 v2 size 67 fails", neg_ok, 0);

        // R4 overlap, control region, window edge
        host_req_size = 32'h100;
        ob_off = 32'h1F0;
        host_cmd(8'h00);
        chk("R4 overlap fails", neg_ok, 0);
        ob_off = 32'h200; ib_off = 32'h10;
        host_cmd(8'h00);
        chk("R4 control region fails", neg_ok, 0);
        ib_off = 32'h100; ob_off = 32'hF80;
        host_cmd(8'h00);
        chk("R4 past window fails", neg_ok, 0);
        ob_off = 32'hF00;
        expect_item(1'b0, 8'hC0, "R4 exact window fit");
        expect_item(1'b1, 8'hFF, "R4 filler");
        host_cmd(8'h00);
        chk("R4 exact fit ok", neg_ok, 1);

        // R5 version 1 keeps configured sizes
        ob_off = 32'h200; host_ver_cur = 16'd1; ib_size = 32'h80; ob_size = 32'h90;
        expect_item(1'b0, 8'hC0, "R5 v1 link");
        expect_item(1'b1, 8'hFF, "R5 filler");
        host_cmd(8'h00);
        chk("R3 version 1", neg_ver, 1);
        chk("R5 v1 ib size kept", neg_ib_size, 32'h80);
        chk("R5 v1 ob size kept", neg_ob_size, 32'h90);

        // R7 / R8 inbound token
        p0 = pkt_cnt;
        host_cmd(8'h01);
        chk("R7 packet event", pkt_cnt, p0 + 1);
        chk("R7 inbound held", ib_held, 1);
        host_cmd(8'h01);
        chk("R7 repeat Tx Begin ignored", pkt_cnt, p0 + 1);
        expect_item(1'b1, 8'h02, "R8 Rx Complete");
        pulse_release();
        chk("R8 inbound released", ib_held, 0);
        host_cmd(8'h01);
        chk("R7 second packet event", pkt_cnt, p0 + 2);
        expect_item(1'b1, 8'h02, "R8 Rx Complete again");
        pulse_release();

        // R9 outbound token
        g0 = gnt_cnt;
        expect_item(1'b1, 8'h01, "R9 Tx Begin");
        do_grant();
        chk("R9 one grant", gnt_cnt, g0 + 1);
        chk("R9 outbound taken", ob_free, 0);
        @(negedge clk); tx_req = 1'b1;
        repeat (12) @(negedge clk); tx_req = 1'b0;
        chk("R9 no second grant", gnt_cnt, g0 + 1);
        host_cmd(8'h02);
        chk("R9 Rx Complete frees outbound", ob_free, 1);
        host_cmd(8'h02);
        chk("R9 stray Rx Complete no effect", ob_free, 1);

        // R2 / R12 queueing behind a full outbound register
        auto_read = 1'b0;
        expect_item(1'b0, 8'hC0, "R2 status");
        expect_item(1'b1, 8'hFF, "R2 filler");
        host_cmd(8'h00);
        chk("R2 obf held", obf, 1);
        o0 = odr_cnt;
        expect_item(1'b0, 8'hC0, "R2 status while obf set");
        host_cmd(8'h00);
        host_cmd(8'h01);
        @(negedge clk); rx_release = 1'b1;
        @(negedge clk); rx_release = 1'b0;
        g0 = gnt_cnt;
        do_grant();
        repeat (10) @(negedge clk);
        chk("R2 nothing written while obf set", odr_cnt, o0);
        chk("R8 held until Rx Complete sent", ib_held, 1);
        expect_item(1'b1, 8'hFF, "R12 filler first");
        expect_item(1'b1, 8'h02, "R12 Rx Complete second");
        expect_item(1'b1, 8'h01, "R12 Tx Begin third");
        host_read();
        chk("R2 one write per read", odr_cnt, o0 + 1);
        host_read();
        host_read();
        chk("R12 all three sent", odr_cnt, o0 + 3);
        chk("R8 inbound released after send", ib_held, 0);
        host_read();
        auto_read = 1'b1;

        // R5 relink resets tokens
        chk("R5 outbound still out", ob_free, 0);
        expect_item(1'b0, 8'hC0, "R5 relink");
        expect_item(1'b1, 8'hFF, "R5 filler");
        host_cmd(8'h00);
        chk("R5 relink frees outbound", ob_free, 1);
        chk("R5 relink clears inbound", ib_held, 0);

        repeat (10) @(negedge clk);
        chk("R13 one read per command", rd_cnt, cmd_seq);
        chk("R12 scoreboard drained", exp_q.size(), 0);

        $display("== %0d vectors applied, %0d miscompares ==", chk_vec + mon_vec, chk_bad + mon_bad);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", chk_vec + mon_vec + 1, chk_bad + mon_bad + 1);
            $finish;
        end
    end

endmodule